// File: doc/BRIEF.md
# Serial/Nibble Transmit Payload Input

This block is the entry point for outbound payload on the transmit side of a line framer. System-side equipment hands it payload either one bit at a time or four bits at a time. The block turns that payload into a single bit stream for the downstream framer. Each outgoing bit is marked by a one-cycle valid strobe. A configuration input chooses between the two interfaces. A second configuration input chooses which timing source paces the transfer: the local transmit clock or the clock recovered from the receive line. Both configuration inputs are captured while reset is held and are frozen after reset.

Every timing source reaches the block as a single-cycle tick strobe that is synchronous to the core clock `clk`, so the whole block runs in one clock domain.

In serial mode, the block samples one payload bit on each tick of the chosen source. In nibble mode, the block drives a quarter-rate nibble clock to the source. It captures the nibble bus on the third tick after each rising edge of that clock and sends the nibble out most significant bit first. It raises an end-of-frame flag for the whole nibble period of the last nibble of each frame. That flag tells the source to begin the next frame.

The output stream has no ready input. The framer downstream is paced by the same timing source and must accept every bit on the cycle its valid strobe is high. The payload source is paced by the ticks, or by the nibble clock, and cannot stall the block either.

Top module: `tpi_payload_in`

## Requirements
- R1: `nib_mode` and `loop_timing` are sampled only while `rst` is high. Changing either of them after reset has no effect until the next reset.
- R2: Serial mode (`nib_mode`=0). On each selected tick, the cycle after the tick shows `out_valid`=1 and `out_bit` equal to the `ser_in` value at the tick.
- R3: In serial mode, `nib_clk` and `nib_eof` stay low, and `nib_in` has no effect on the output.
- R4: With `loop_timing`=1 the selected tick is `loop_tick`, and `loc_tick` is ignored. With `loop_timing`=0 the selected tick is `loc_tick`, and `loop_tick` is ignored.
- R5: Nibble mode. `nib_clk` is a registered output that changes only on selected ticks. It is high after the first and second of every four ticks and low after the third and fourth. The first tick after reset raises it.
- R6: Nibble mode. `nib_in` is captured on the third tick after each rising edge of `nib_clk`. Its value on any other tick has no effect.
- R7: Nibble mode. On the capture tick, `out_bit` becomes `nib_in[3]`. The next three ticks give bits 2, 1 and 0, each with `out_valid`=1. No bit is output before the first capture, and `ser_in` has no effect.
- R8: A frame is 1536 bits, or 384 nibbles. `nib_eof` goes high on the capture of the 384th nibble of a frame and stays high until the next capture clears it. The count then restarts for the next frame.
- R9: While `rst` is high, `nib_clk`, `nib_eof` and `out_valid` are low in the cycle after each clock edge.
- R10: In a cycle after a clock edge with no selected tick, `out_valid` is low and `nib_clk` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset; also loads the configuration |
| nib_mode | input | 1 | 0 = serial interface, 1 = nibble interface (sampled in reset) |
| loop_timing | input | 1 | 0 = local timing, 1 = loop timing (sampled in reset) |
| loc_tick | input | 1 | One-cycle strobe per rising edge of the local transmit clock |
| loop_tick | input | 1 | One-cycle strobe per rising edge of the recovered receive clock |
| ser_in | input | 1 | Serial payload bit |
| nib_in | input | 4 | Nibble payload, bit 3 sent first |
| nib_clk | output | 1 | Quarter-rate nibble clock to the source |
| nib_eof | output | 1 | High during the last nibble period of a frame |
| out_valid | output | 1 | One-cycle strobe marking a valid `out_bit` |
| out_bit | output | 1 | Serialized payload bit |

## Verification
The assertions assume the following. Ticks are strobes synchronous to `clk`. The configuration inputs matter only while reset is held. In nibble mode, ticks keep arriving so that each captured nibble is fully shifted out before the next capture. The stimulus changes inputs only on the falling clock edge and raises each tick for exactly one cycle. It reconfigures only through a reset, except for one test that changes the configuration on purpose without a reset, to show that the change is ignored. The nibble run delivers an unbroken stream of ticks, so the serializer always finishes a nibble before the next one is captured.

// File: rtl/tpi_pkg.sv
package tpi_pkg;
  typedef enum logic { IF_SERIAL = 1'b0, IF_NIBBLE = 1'b1 } if_mode_e;
  typedef enum logic { TM_LOCAL = 1'b0, TM_LOOP = 1'b1 } tmg_src_e;
endpackage

// File: rtl/tpi_tick_sel.sv
module tpi_tick_sel
  import tpi_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     nib_mode,
  input  logic     loop_timing,
  input  logic     loc_tick,
  input  logic     loop_tick,
  output if_mode_e mode_q,
  output logic     tick
);
  tmg_src_e src_q;

  // Configuration is loaded during reset and frozen afterwards
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= nib_mode ? IF_NIBBLE : IF_SERIAL;
      src_q  <= loop_timing ? TM_LOOP : TM_LOCAL;
    end
  end

  always_comb begin
    tick = (src_q == TM_LOOP) ? loop_tick : loc_tick;
  end

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
    !rst |=> $stable(mode_q) && $stable(src_q)); // R1
endmodule

// File: rtl/tpi_nib_timer.sv
module tpi_nib_timer
  import tpi_pkg::*;
#(
  parameter int NIB_W     = 4,
  parameter int CAP_PHASE = 2
) (
  input  logic     clk,
  input  logic     rst,
  input  if_mode_e mode_q,
  input  logic     tick,
  output logic     nib_clk,
  output logic     cap
);
  localparam int PH_W  = (NIB_W > 2) ? $clog2(NIB_W) : 1;
  localparam int HI_PH = NIB_W / 2;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(NIB_W - 1);

  logic [PH_W-1:0] ph, ph_nxt;
  logic            run;

  always_comb begin
    run    = tick && (mode_q == IF_NIBBLE);
    ph_nxt = (ph == PH_LAST) ? '0 : ph + PH_W'(1);
    cap    = run && (ph == PH_W'(CAP_PHASE));
  end

  // Phase parks on its last value so the first tick raises the clock
  always_ff @(posedge clk) begin
    if (rst) begin
      ph      <= PH_LAST;
      nib_clk <= 1'b0;
    end else if (run) begin
      ph      <= ph_nxt;
      nib_clk <= (32'(ph_nxt) < HI_PH);
    end
  end

  AST_NIBCLK_RISE_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    $rose(nib_clk) |-> $past(tick)); // R5
  AST_NIBCLK_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(nib_clk)); // R10
  AST_CAP_IN_LOW_HALF: assert property (@(posedge clk) disable iff (rst)
    cap |-> !nib_clk); // R6
endmodule

// File: rtl/tpi_frame_cnt.sv
module tpi_frame_cnt #(
  parameter int FRAME_NIBS = 384
) (
  input  logic clk,
  input  logic rst,
  input  logic cap,
  output logic nib_eof
);
  localparam int CNT_W = (FRAME_NIBS > 2) ? $clog2(FRAME_NIBS) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_NIBS - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      nib_eof <= 1'b0;
    end else if (cap) begin
      nib_eof <= (cnt == CNT_LAST);
      cnt     <= (cnt == CNT_LAST) ? '0 : cnt + CNT_W'(1);
    end
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_LAST); // R8
  AST_EOF_RISE_ON_CAP: assert property (@(posedge clk) disable iff (rst)
    $rose(nib_eof) |-> $past(cap)); // R8
  AST_EOF_FALL_ON_CAP: assert property (@(posedge clk) disable iff (rst)
    $fell(nib_eof) |-> $past(cap) || $past(rst)); // R8
endmodule

// File: rtl/tpi_serializer.sv
module tpi_serializer
  import tpi_pkg::*;
#(
  parameter int NIB_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  if_mode_e         mode_q,
  input  logic             tick,
  input  logic             cap,
  input  logic             ser_in,
  input  logic [NIB_W-1:0] nib_in,
  output logic             out_valid,
  output logic             out_bit
);
  localparam int LW = (NIB_W > 2) ? $clog2(NIB_W) : 1;

  logic [NIB_W-2:0] sh;
  logic [LW-1:0]    left;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_bit   <= 1'b0;
      sh        <= '0;
      left      <= '0;
    end else if (!tick) begin
      out_valid <= 1'b0;
    end else if (mode_q == IF_SERIAL) begin
      out_valid <= 1'b1;
      out_bit   <= ser_in;
    end else if (cap) begin
      out_valid <= 1'b1;
      out_bit   <= nib_in[NIB_W-1];
      sh        <= nib_in[NIB_W-2:0];
      left      <= LW'(NIB_W - 1);
    end else if (left != '0) begin
      out_valid <= 1'b1;
      out_bit   <= sh[NIB_W-2];
      sh        <= sh << 1;
      left      <= left - LW'(1);
    end else begin
      out_valid <= 1'b0;
    end
  end

  AST_VALID_NEEDS_TICK: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(tick)); // R10
  AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (rst)
    cap |-> left == '0); // R7
endmodule

// File: rtl/tpi_payload_in.sv
module tpi_payload_in
  import tpi_pkg::*;
#(
  parameter int FRAME_BITS = 1536,
  parameter int NIB_W      = 4,
  parameter int CAP_PHASE  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             nib_mode,
  input  logic             loop_timing,
  input  logic             loc_tick,
  input  logic             loop_tick,
  input  logic             ser_in,
  input  logic [NIB_W-1:0] nib_in,
  output logic             nib_clk,
  output logic             nib_eof,
  output logic             out_valid,
  output logic             out_bit
);
  localparam int FRAME_NIBS = FRAME_BITS / NIB_W;

  if_mode_e mode_q;
  logic     tick;
  logic     cap;

  tpi_tick_sel u_sel (
    .clk(clk), .rst(rst), .nib_mode(nib_mode), .loop_timing(loop_timing),
    .loc_tick(loc_tick), .loop_tick(loop_tick), .mode_q(mode_q), .tick(tick)
  );

  tpi_nib_timer #(.NIB_W(NIB_W), .CAP_PHASE(CAP_PHASE)) u_tmr (
    .clk(clk), .rst(rst), .mode_q(mode_q), .tick(tick),
    .nib_clk(nib_clk), .cap(cap)
  );

  tpi_frame_cnt #(.FRAME_NIBS(FRAME_NIBS)) u_frm (
    .clk(clk), .rst(rst), .cap(cap), .nib_eof(nib_eof)
  );

  tpi_serializer #(.NIB_W(NIB_W)) u_ser (
    .clk(clk), .rst(rst), .mode_q(mode_q), .tick(tick), .cap(cap),
    .ser_in(ser_in), .nib_in(nib_in), .out_valid(out_valid), .out_bit(out_bit)
  );

  AST_SERIAL_QUIET: assert property (@(posedge clk) disable iff (rst)
    mode_q == IF_SERIAL |-> !nib_clk && !nib_eof); // R3
  AST_RESET_CLEARS: assert property (@(posedge clk)
    $past(rst) |-> !nib_clk && !nib_eof && !out_valid); // R9
endmodule

// File: tb/tb_tpi_payload_in.sv
`timescale 1ns/1ps
module tb_tpi_payload_in;
  localparam int FN = 384;
  // {tick, ser_in}
  localparam logic [1:0] SVEC [12] = '{2'b11, 2'b10, 2'b01, 2'b11, 2'b11, 2'b00,
                                       2'b10, 2'b11, 2'b01, 2'b10, 2'b11, 2'b10};
  localparam logic [3:0] NVEC [8] = '{4'hA, 4'h5, 4'h3, 4'hC, 4'hF, 4'h0, 4'h9, 4'h6};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic nib_mode = 1'b0, loop_timing = 1'b0;
  logic loc_tick = 1'b0, loop_tick = 1'b0, ser_in = 1'b0;
  logic [3:0] nib_in = 4'h0;
  logic nib_clk, nib_eof, out_valid, out_bit;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  tpi_payload_in dut (
    .clk(clk), .rst(rst), .nib_mode(nib_mode), .loop_timing(loop_timing),
    .loc_tick(loc_tick), .loop_tick(loop_tick), .ser_in(ser_in), .nib_in(nib_in),
    .nib_clk(nib_clk), .nib_eof(nib_eof), .out_valid(out_valid), .out_bit(out_bit)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", rq, act, exp, $time);
    end
  endtask

  task automatic step(input logic lt, input logic pt, input logic s, input logic [3:0] n);
    loc_tick = lt; loop_tick = pt; ser_in = s; nib_in = n;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset(input logic nm, input logic lp);
    nib_mode = nm; loop_timing = lp; rst = 1'b1;
    step(1'b1, 1'b1, 1'b1, 4'hF);
    step(1'b1, 1'b1, 1'b1, 4'hF);
    chk(!nib_clk && !nib_eof && !out_valid, "R9 reset outputs",
        {nib_clk, nib_eof, out_valid}, 0);
    rst = 1'b0;
  endtask

  initial begin
    #(20 * 150000);
    chk(1'b0, "watchdog", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    // Serial mode, local timing, vector table
    do_reset(1'b0, 1'b0);
    foreach (SVEC[i]) begin
      step(SVEC[i][1], 1'b0, SVEC[i][0], 4'(i * 5));
      chk(out_valid == SVEC[i][1], "R2 valid follows tick", out_valid, SVEC[i][1]);
      if (SVEC[i][1]) chk(out_bit == SVEC[i][0], "R2 serial bit", out_bit, SVEC[i][0]);
      else chk(!out_valid, "R10 no tick no valid", out_valid, 0);
      chk(!nib_clk && !nib_eof, "R3 nibble outputs quiet", {nib_clk, nib_eof}, 0);
    end

    // Loop timing in serial mode
    do_reset(1'b0, 1'b1);
    step(1'b1, 1'b0, 1'b1, 4'h0);
    chk(!out_valid, "R4 local tick ignored in loop timing", out_valid, 0);
    step(1'b0, 1'b1, 1'b1, 4'h0);
    chk(out_valid && out_bit, "R4 loop tick used", {out_valid, out_bit}, 3);
    step(1'b0, 1'b1, 1'b0, 4'h0);
    chk(out_valid && !out_bit, "R4 loop tick bit 0", {out_valid, out_bit}, 2);
    // Reconfigure without reset: must be ignored
    nib_mode = 1'b1; loop_timing = 1'b0;
    step(1'b1, 1'b0, 1'b1, 4'hF);
    chk(!out_valid, "R1 timing source frozen", out_valid, 0);
    chk(!nib_clk, "R1 mode frozen", nib_clk, 0);
    step(1'b0, 1'b1, 1'b1, 4'h0);
    chk(out_valid && out_bit && !nib_clk, "R1 still serial on loop tick",
        {out_valid, out_bit, nib_clk}, 6);

    // Nibble mode, local timing, full frame and wrap
    do_reset(1'b1, 1'b0);
    for (int n = 0; n < FN + 2; n++) begin
      logic [3:0] v, pv;
      v  = (n < 8) ? NVEC[n] : 4'((n * 7 + 3) & 15);
      pv = (n == 0) ? 4'h0 : ((n - 1 < 8) ? NVEC[n - 1] : 4'(((n - 1) * 7 + 3) & 15));
      for (int j = 1; j <= 4; j++) begin
        logic eexp;
        step(1'b1, 1'b0, 1'(n ^ j), (j == 4) ? v : ~v);
        chk(nib_clk == (j <= 2), "R5 nibble clock phase", nib_clk, (j <= 2));
        if (j == 4) begin
          chk(out_valid && out_bit == v[3], "R6 capture on third tick after rise",
              {out_valid, out_bit}, {1'b1, v[3]});
        end else if (n == 0) begin
          chk(!out_valid, "R7 nothing before first capture", out_valid, 0);
        end else begin
          chk(out_valid && out_bit == pv[3 - j], "R7 MSB-first shift",
              {out_valid, out_bit}, {1'b1, pv[3 - j]});
        end
        eexp = (n == FN - 1 && j == 4) || (n == FN && j < 4);
        chk(nib_eof == eexp, "R8 end-of-frame flag", nib_eof, eexp);
      end
    end

    // Idle cycles in nibble mode
    begin
      logic held;
      held = nib_clk;
      step(1'b0, 1'b1, 1'b1, 4'hF);
      chk(!out_valid && nib_clk == held, "R10 idle holds clock",
          {out_valid, nib_clk}, {1'b0, held});
      step(1'b0, 1'b0, 1'b0, 4'h0);
      chk(!out_valid && nib_clk == held, "R10 idle second cycle",
          {out_valid, nib_clk}, {1'b0, held});
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule